// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

This block turns one fast oscillator clock into the clocks a small processor system needs. The oscillator itself is passed straight through. A processor clock is derived at one third of the oscillator rate, high for one oscillator period out of three. A peripheral clock is derived at one sixth of the oscillator rate with an even duty cycle. Its rising edges line up with every second rising edge of the processor clock.

A synchronization input, active high, freezes both dividers in a known idle phase. When several generators share the oscillator and release this input on the same edge, they run in lockstep. An active-low reset request enters through a two-stage synchronizer in the oscillator domain. It then reaches an active-high processor reset output. While the dividers run, that output changes only on the oscillator edge where the processor clock falls, which keeps it away from the processor's sampling edge. While the dividers are held, it follows the synchronizer on every oscillator edge.

The divider is a four-state machine: `PH_HOLD` (frozen), `PH_HIGH` (processor clock high), `PH_LOW_A` and `PH_LOW_B` (the two low periods). The transitions are:
- `hold_enter`: any state goes to `PH_HOLD` while the sync input is high.
- `hold_leave`: `PH_HOLD` goes to `PH_HIGH` once the sync input is low.
- `fall`: `PH_HIGH` goes to `PH_LOW_A`.
- `gap`: `PH_LOW_A` goes to `PH_LOW_B`.
- `wrap`: `PH_LOW_B` goes to `PH_HIGH`.

Top module: `cpuclk_gen`

## Requirements
- R1: `osc_out` is a direct copy of `osc_clk`: high in the high half of each oscillator period and low in the low half.
- R2: When the dividers run, `cpu_clk` repeats the pattern high, low, low, one value per oscillator edge. This gives a period of three oscillator cycles and a one-third duty cycle.
- R3: `per_clk` toggles on every oscillator edge where `cpu_clk` rises, and at no other edge. This gives a period of six oscillator cycles, high for three of them.
- R4: After any oscillator edge that samples `sync_hold` high, `cpu_clk` and `per_clk` are both 0. At the first edge that samples `sync_hold` low, both go to 1.
- R5: While the dividers run, `cpu_rst` takes the value of `rst_req_n` inverted, delayed by two oscillator flops. It changes only on an oscillator edge where `cpu_clk` falls. A request driven just before edge J therefore shows on `cpu_rst` after the first edge E ≥ J+2 at which `cpu_clk` falls.
- R6: While `sync_hold` is high, `cpu_rst` updates on every oscillator edge. It equals the inverted `rst_req_n` three edges after that input changes, and outputs stay low (reset state: `cpu_rst`=1, `cpu_clk`=0, `per_clk`=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Fast oscillator clock |
| sync_hold | input | 1 | Active-high divider hold for multi-generator alignment |
| rst_req_n | input | 1 | Active-low reset request, asynchronous |
| osc_out | output | 1 | Pass-through copy of the oscillator |
| cpu_clk | output | 1 | Processor clock, oscillator/3, 33% high |
| per_clk | output | 1 | Peripheral clock, oscillator/6, 50% high |
| cpu_rst | output | 1 | Active-high processor reset, registered |

## Verification
`cpu_clk` and `per_clk` are registered, so each takes its new value on the oscillator edge that samples `sync_hold`. The bench numbers edges from the release edge (edge 1) and expects `cpu_clk` high after edge k when (k-1) mod 3 is 0, and `per_clk` high when ((k-1)/3) is even. A change of `rst_req_n` driven after edge j passes two synchronizer flops. It then appears after the first edge e ≥ j+3 with (e-2) mod 3 = 0, and the bench computes that edge for each phase of the request. Every sample is taken 2 ns after a rising edge, where all registered results of that edge are settled and no later edge has arrived.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    // Phase of the divide-by-three machine; PH_HIGH is the only phase
    // in which the processor clock is high.
    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,
        PH_HIGH  = 2'd1,
        PH_LOW_A = 2'd2,
        PH_LOW_B = 2'd3
    } phase_e;

    localparam int unsigned RST_SYNC_DEPTH_DEFAULT = 2;

endpackage

// File: rtl/cpuclk_phase_fsm.sv
module cpuclk_phase_fsm
    import cpuclk_pkg::*;
(
    input  logic osc_clk,
    input  logic sync_hold,
    output logic cpu_clk,
    output logic rise_stb,
    output logic fall_stb
);

    phase_e state_q;
    phase_e state_d;

    // State register
    always_ff @(posedge osc_clk) begin
        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (sync_hold) begin
            state_d = PH_HOLD;                  // hold_enter
        end else begin
            unique case (state_q)
                PH_HOLD:  state_d = PH_HIGH;    // hold_leave
                PH_HIGH:  state_d = PH_LOW_A;   // fall
                PH_LOW_A: state_d = PH_LOW_B;   // gap
                PH_LOW_B: state_d = PH_HIGH;    // wrap
                default:  state_d = PH_HOLD;
            endcase
        end
    end

    // Edge strobes for the neighbours: this oscillator edge raises or
    // lowers the processor clock.
    assign rise_stb = (state_d == PH_HIGH);
    assign fall_stb = (state_q == PH_HIGH);

    // Output register: the processor clock comes straight from a flop
    always_ff @(posedge osc_clk) begin
        cpu_clk <= (state_d == PH_HIGH);
    end

    AST_CPU_SINGLE_HIGH: assert property (@(posedge osc_clk) disable iff (sync_hold)
        cpu_clk |=> !cpu_clk);                                   // R2

    AST_CPU_TWO_LOW: assert property (@(posedge osc_clk) disable iff (sync_hold)
        (!cpu_clk && !$past(cpu_clk)) |=> cpu_clk);              // R2

endmodule

// File: rtl/cpuclk_per_toggle.sv
module cpuclk_per_toggle (
    input  logic osc_clk,
    input  logic sync_hold,
    input  logic rise_stb,
    output logic per_clk
);

    // Toggles once per processor-clock rising edge, cleared while held
    always_ff @(posedge osc_clk) begin
        if (sync_hold) begin
            per_clk <= 1'b0;
        end else if (rise_stb) begin
            per_clk <= ~per_clk;
        end
    end

    AST_PER_ONLY_ON_RISE: assert property (@(posedge osc_clk) disable iff (sync_hold)
        !rise_stb |=> $stable(per_clk));                         // R3

endmodule

// File: rtl/cpuclk_rst_sync.sv
module cpuclk_rst_sync #(
    parameter int unsigned SYNC_DEPTH = cpuclk_pkg::RST_SYNC_DEPTH_DEFAULT
) (
    input  logic osc_clk,
    input  logic sync_hold,
    input  logic fall_stb,
    input  logic rst_req_n,
    output logic cpu_rst
);

    localparam int unsigned LAST = SYNC_DEPTH - 1;

    logic [SYNC_DEPTH-1:0] chain_q;

    // Synchronizer: the request enters at bit 0 and moves up one per edge
    always_ff @(posedge osc_clk) begin
        chain_q <= {chain_q[SYNC_DEPTH-2:0], ~rst_req_n};
    end

    // Capture on the processor-clock falling edge, or freely while held
    always_ff @(posedge osc_clk) begin
        if (sync_hold || fall_stb) begin
            cpu_rst <= chain_q[LAST];
        end
    end

    initial begin
        if (SYNC_DEPTH < 2) $error("SYNC_DEPTH must be at least 2");
    end

endmodule

// File: rtl/cpuclk_gen.sv
module cpuclk_gen #(
    parameter int unsigned SYNC_DEPTH = cpuclk_pkg::RST_SYNC_DEPTH_DEFAULT
) (
    input  logic osc_clk,
    input  logic sync_hold,
    input  logic rst_req_n,
    output logic osc_out,
    output logic cpu_clk,
    output logic per_clk,
    output logic cpu_rst
);

    logic rise_stb;
    logic fall_stb;
    logic held_q;

    assign osc_out = osc_clk;

    cpuclk_phase_fsm u_phase (
        .osc_clk  (osc_clk),
        .sync_hold(sync_hold),
        .cpu_clk  (cpu_clk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    cpuclk_per_toggle u_per (
        .osc_clk  (osc_clk),
        .sync_hold(sync_hold),
        .rise_stb (rise_stb),
        .per_clk  (per_clk)
    );

    cpuclk_rst_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_rst (
        .osc_clk  (osc_clk),
        .sync_hold(sync_hold),
        .fall_stb (fall_stb),
        .rst_req_n(rst_req_n),
        .cpu_rst  (cpu_rst)
    );

    // Remembers that the previous edge saw the hold, for assertion gating
    always_ff @(posedge osc_clk) begin
        held_q <= sync_hold;
    end

    AST_HOLD_QUIET: assert property (@(posedge osc_clk)
        sync_hold |=> (!cpu_clk && !per_clk));                   // R4

    AST_RELEASE_RISE: assert property (@(posedge osc_clk)
        (held_q && !sync_hold) |=> (cpu_clk && per_clk));        // R4

    AST_PER_ON_CPU_RISE: assert property (@(posedge osc_clk) disable iff (sync_hold || held_q)
        $rose(cpu_clk) |-> (per_clk != $past(per_clk)));         // R3

    AST_RST_AT_FALL: assert property (@(posedge osc_clk) disable iff (sync_hold || held_q)
        !$stable(cpu_rst) |-> $fell(cpu_clk));                   // R5

endmodule

// File: tb/cpuclk_gen_bench.sv
`timescale 1ns/1ps
module cpuclk_gen_bench;

    logic osc_clk = 1'b0;
    logic sync_hold = 1'b1;
    logic rst_req_n = 1'b0;
    logic osc_out, cpu_clk, per_clk, cpu_rst;

    int errors = 0;
    int checks = 0;
    int k = 0;

    always #5 osc_clk = ~osc_clk;

    cpuclk_gen u_cpuclk_gen (
        .osc_clk  (osc_clk),
        .sync_hold(sync_hold),
        .rst_req_n(rst_req_n),
        .osc_out  (osc_out),
        .cpu_clk  (cpu_clk),
        .per_clk  (per_clk),
        .cpu_rst  (cpu_rst)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at edge %0d: actual=%b expected=%b", tag, k, act, exp);
        end
    endtask

    // One oscillator edge; inputs are driven and outputs sampled 2 ns later
    task automatic tick();
        @(posedge osc_clk);
        #2;
        k++;
    endtask

    function automatic int first_fall(input int from);
        int e = from;
        while ((e - 2) % 3 != 0) e++;
        return e;
    endfunction

    task automatic check_clocks();
        check(cpu_clk, ((k - 1) % 3) == 0, "R2 cpu_clk");
        check(per_clk, (((k - 1) / 3) % 2) == 0, "R3 per_clk");
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Reset state under hold with the request active (R6, R4)
        repeat (4) tick();
        check(cpu_rst, 1'b1, "R6 reset state cpu_rst");
        check(cpu_clk, 1'b0, "R4 reset state cpu_clk");
        check(per_clk, 1'b0, "R4 reset state per_clk");
        // R1: pass-through copy in both halves
        check(osc_out, 1'b1, "R1 osc_out high half");
        #5;
        check(osc_out, 1'b0, "R1 osc_out low half");
        #(-0); // keep alignment
        @(posedge osc_clk); #2;
        // R6: request withdrawn while held, seen three edges later
        rst_req_n = 1'b1;
        tick(); tick();
        check(cpu_rst, 1'b1, "R6 still asserted after two edges");
        tick();
        check(cpu_rst, 1'b0, "R6 released after three edges");

        // R2/R3/R4 sweep: re-hold at every phase of the six-cycle pattern
        for (int ph = 0; ph < 6; ph++) begin
            sync_hold = 1'b1;
            for (int h = 0; h < 3; h++) begin
                tick();
                check(cpu_clk, 1'b0, "R4 cpu_clk held low");
                check(per_clk, 1'b0, "R4 per_clk held low");
            end
            sync_hold = 1'b0;
            k = 0;
            tick();
            check(cpu_clk, 1'b1, "R4 cpu_clk first edge after release");
            check(per_clk, 1'b1, "R4 per_clk first edge after release");
            for (int c = 0; c < 23 + ph; c++) begin
                tick();
                check_clocks();
                check(osc_out, 1'b1, "R1 osc_out sampled high");
            end
        end

        // R5 sweep: request raised and dropped at each processor phase
        for (int j = 3; j < 6; j++) begin
            int ea;
            int ed;
            sync_hold = 1'b1;
            rst_req_n = 1'b1;
            repeat (4) tick();
            check(cpu_rst, 1'b0, "R6 clean start");
            sync_hold = 1'b0;
            k = 0;
            ea = first_fall(j + 3);
            ed = first_fall(j + 10 + 3);
            for (int c = 0; c < 36; c++) begin
                tick();
                check_clocks();
                check(cpu_rst, (k >= ea) && (k < ed), "R5 cpu_rst timing");
                if (k == j) rst_req_n = 1'b0;
                if (k == j + 10) rst_req_n = 1'b1;
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule